// File: doc/BRIEF.md
# Keyed Watchdog Enable Sequencer

This block guards a 64-bit timer that has been switched into its watchdog role. Software arms the watchdog with two ordered key writes to a control register. After arming, an internal counter advances on each timer tick. Software must repeat the same two-key pair before the counter reaches a programmed period. Each completed pair restarts the count from zero.

A late service raises a reset request. So does any write while armed that breaks the key protocol. The request is sticky and stays high until the block's own reset. Before arming, stray writes do nothing, so the watchdog cannot be tripped by accident while it is still dormant. Key writes and ticks count only while the global timer mode selects watchdog operation and both timer halves are out of reset.

Top module: `keywd_ctrl`

## Requirements
- R1: After reset, `bite_req` and `wd_live` are both 0.
- R2: A write or tick has an effect only while `mode_sel` equals 2 and `halves_run` equals 2'b11. Otherwise writes are ignored and the counter holds.
- R3: A write is a first key when bit 14 is 1 and bits 31:16 equal 16'hA5C6. It is a second key when bit 14 is 1 and bits 31:16 equal 16'hDA7E. Starting from idle, a first key followed by a second key makes `wd_live` 1 from the edge of the second write onward.
- R4: Until `wd_live` is 1, no write other than the keys of R3 changes state, and no write raises `bite_req`. This includes a second key seen in idle.
- R5: Once `wd_live` is 1, it stays 1 until `rst_n` is applied, whatever is written.
- R6: The counter is cleared to 0 on the arming edge. It then advances by one on every edge where `tick` is 1. On the edge after the count equals `period`, `bite_req` becomes 1.
- R7: While live, a first key followed by a second key clears the counter to 0, so the deadline moves to `period`+1 ticks after the second write.
- R8: While live, `bite_req` rises on the edge of any write that is not the expected key. After a service first key, only a second key is expected; otherwise only a first key is expected. Examples are 32'h00004000, a lone second key, and a wrong value after a first key.
- R9: Once `bite_req` is 1, it stays 1 until `rst_n` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the watchdog control register |
| wr_data | input | 32 | Write data: bit 14 is enable, bits 31:16 are the key |
| mode_sel | input | 2 | Global timer mode field; 2 selects watchdog |
| halves_run | input | 2 | Out-of-reset flags for the two timer halves |
| tick | input | 1 | Counter advance enable |
| period | input | CNT_W | Deadline count |
| bite_req | output | 1 | Sticky reset request |
| wd_live | output | 1 | Watchdog armed |

## Verification
The bench builds the block with CNT_W at 16 and a period of 12. This lets the deadline be reached within a few dozen cycles, so every arming and service can be run through to the exact edge where the request rises. A behavioural model is compared against the design on every clock. Timed checks cover the following:
- ignored writes before arming;
- the mode gate;
- a stalled tick;
- each kind of protocol violation after arming.

// File: rtl/keywd_pkg.sv
package keywd_pkg;
  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_PRIMED = 2'd1,
    WD_LIVE   = 2'd2,
    WD_SVC    = 2'd3
  } wd_state_t;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam int          EN_POS     = 14;
  localparam logic [1:0]  MODE_WDOG  = 2'd2;

  function automatic logic [15:0] key_of(input logic [31:0] d);
    return d[31:16];
  endfunction

  function automatic logic is_first_key(input logic [31:0] d);
    return d[EN_POS] && (key_of(d) == KEY_FIRST);
  endfunction

  function automatic logic is_second_key(input logic [31:0] d);
    return d[EN_POS] && (key_of(d) == KEY_SECOND);
  endfunction

  function automatic logic mode_valid(input logic [1:0] m, input logic [1:0] h);
    return (m == MODE_WDOG) && (h == 2'b11);
  endfunction
endpackage

// File: rtl/keywd_decode.sv
module keywd_decode
  import keywd_pkg::*;
(
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [1:0]  mode_sel,
  input  logic [1:0]  halves_run,
  output logic        mode_ok,
  output logic        fire,
  output logic        key_first,
  output logic        key_second
);
  logic unused_low_bits;

  assign unused_low_bits = ^{wr_data[15], wr_data[13:0]};
  assign mode_ok    = mode_valid(mode_sel, halves_run);
  assign fire       = wr_en && mode_ok;
  assign key_first  = is_first_key(wr_data);
  assign key_second = is_second_key(wr_data);
endmodule

// File: rtl/keywd_fsm.sv
module keywd_fsm
  import keywd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic key_first,
  input  logic key_second,
  output logic live,
  output logic arm_evt,
  output logic svc_evt,
  output logic bad_evt
);
  wd_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    arm_evt  = 1'b0;
    svc_evt  = 1'b0;
    bad_evt  = 1'b0;
    if (fire) begin
      unique case (state)
        WD_IDLE:   if (key_first) state_nx = WD_PRIMED;
        WD_PRIMED: if (key_second) begin
                     state_nx = WD_LIVE;
                     arm_evt  = 1'b1;
                   end
        WD_LIVE:   if (key_first) state_nx = WD_SVC;
                   else bad_evt = 1'b1;
        WD_SVC:    if (key_second) begin
                     state_nx = WD_LIVE;
                     svc_evt  = 1'b1;
                   end else bad_evt = 1'b1;
        default:   state_nx = WD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WD_IDLE;
    else        state <= state_nx;
  end

  assign live = (state == WD_LIVE) || (state == WD_SVC);

  // R5: armed watchdog never drops back
  p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> live);

  // R4: no protocol error can be flagged before arming
  p_dormant_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !bad_evt);

  // R2: without a fired write the state holds
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(state));
endmodule

// File: rtl/keywd_count.sv
module keywd_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             live,
  input  logic [CNT_W-1:0] period,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + ONE;
  end

  assign hit = live && (cnt == period);

  // R7: a clear request zeroes the count
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R6: the count is frozen without a run or clear
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/keywd_ctrl.sv
module keywd_ctrl
  import keywd_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       halves_run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             bite_req,
  output logic             wd_live
);
  logic mode_ok, fire, key_first, key_second;
  logic arm_evt, svc_evt, bad_evt, cnt_hit, cnt_run;

  keywd_decode u_dec (
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .mode_sel   (mode_sel),
    .halves_run (halves_run),
    .mode_ok    (mode_ok),
    .fire       (fire),
    .key_first  (key_first),
    .key_second (key_second)
  );

  keywd_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .key_first  (key_first),
    .key_second (key_second),
    .live       (wd_live),
    .arm_evt    (arm_evt),
    .svc_evt    (svc_evt),
    .bad_evt    (bad_evt)
  );

  assign cnt_run = wd_live && !bite_req && tick && mode_ok;

  keywd_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (arm_evt || svc_evt),
    .run    (cnt_run),
    .live   (wd_live),
    .period (period),
    .hit    (cnt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bite_req <= 1'b0;
    else        bite_req <= bite_req || bad_evt || cnt_hit;
  end

  // R8: a protocol break requests reset on the next cycle
  p_bad_bites_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> bite_req);

  // R6: reaching the period requests reset
  p_hit_bites_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit |=> bite_req);

  // R9: the request is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bite_req |=> bite_req);

  // R4: a dormant watchdog never requests reset
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_live && !bite_req) |=> !bite_req);

  // R2: with the mode gate closed, the armed flag holds
  p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> $stable(wd_live));
endmodule

// File: tb/keywd_ctrl_bench.sv
module keywd_ctrl_bench;
  localparam int CW = 16;
  localparam int P  = 12;
  localparam logic [31:0] KA  = 32'hA5C6_4000;
  localparam logic [31:0] KB  = 32'hDA7E_4000;
  localparam logic [31:0] BAD = 32'h0000_4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [1:0]    mode_sel = 2'd2;
  logic [1:0]    halves_run = 2'b11;
  logic          tick = 1'b1;
  logic [CW-1:0] period = CW'(P);
  logic          bite_req, wd_live;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  keywd_ctrl #(.CNT_W(CW)) u_keywd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_sel(mode_sel), .halves_run(halves_run), .tick(tick),
    .period(period), .bite_req(bite_req), .wd_live(wd_live)
  );

  // behavioural reference: 0 idle, 1 primed, 2 armed, 3 armed with service pending
  int  m_st;
  int  m_cnt;
  bit  m_bite;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_bite = 0;
    end else begin
      bit ok, fire, ka, kb, lv, hit, bad, clr;
      ok   = (mode_sel == 2) && (halves_run == 3);
      fire = wr_en && ok;
      ka   = wr_data[14] && (wr_data[31:16] == 16'hA5C6);
      kb   = wr_data[14] && (wr_data[31:16] == 16'hDA7E);
      lv   = (m_st >= 2);
      hit  = lv && (m_cnt == int'(period));
      bad  = 0; clr = 0;
      if (fire) begin
        if (m_st == 0)      begin if (ka) m_st = 1; end
        else if (m_st == 1) begin if (kb) begin m_st = 2; clr = 1; end end
        else if (m_st == 2) begin if (ka) m_st = 3; else bad = 1; end
        else                begin if (kb) begin m_st = 2; clr = 1; end else bad = 1; end
      end
      if (clr) m_cnt = 0;
      else if (lv && !m_bite && tick && ok) m_cnt = m_cnt + 1;
      m_bite = m_bite | bad | hit;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 R8 R9 model bite_req", 64'(bite_req), 64'(m_bite));
      chk("R3 R5 model wd_live", 64'(wd_live), 64'(m_st >= 2));
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
  endtask

  task automatic arm();
    wr(KA); wr(KB);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    finish_run();
  end

  initial begin
    wait_n(2);
    chk("R1 reset bite_req", 64'(bite_req), 64'd0);
    chk("R1 reset wd_live", 64'(wd_live), 64'd0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 after release", 64'(wd_live), 64'd0);

    // R2: mode gate
    mode_sel = 2'd0; arm();
    chk("R2 wrong mode ignores keys", 64'(wd_live), 64'd0);
    mode_sel = 2'd2; halves_run = 2'b01; arm();
    chk("R2 half in reset ignores keys", 64'(wd_live), 64'd0);
    halves_run = 2'b11;

    // R4: dormant writes ignored
    wr(32'h1234_4000); wr(BAD); wr(KB); wr(32'hA5C6_0000); wr(KB);
    chk("R4 dormant no bite", 64'(bite_req), 64'd0);
    chk("R4 dormant not live", 64'(wd_live), 64'd0);
    wr(KA); wr(BAD); wr(KA);
    chk("R4 primed junk ignored", 64'(bite_req), 64'd0);
    wr(KB);
    chk("R3 armed after key pair", 64'(wd_live), 64'd1);

    // R6: exact deadline from arming
    wait_n(P);
    chk("R6 no bite at count==period", 64'(bite_req), 64'd0);
    wait_n(1);
    chk("R6 bite edge after period", 64'(bite_req), 64'd1);
    wr(KA); wr(KB); wait_n(20);
    chk("R9 sticky after service", 64'(bite_req), 64'd1);
    chk("R5 still live", 64'(wd_live), 64'd1);
    do_reset();
    chk("R9 cleared by reset", 64'(bite_req), 64'd0);
    chk("R5 reset returns idle", 64'(wd_live), 64'd0);

    // R7: service restarts count
    arm(); wait_n(8); wr(KA); wr(KB); wait_n(10);
    chk("R7 serviced no bite", 64'(bite_req), 64'd0);
    wait_n(P - 10);
    chk("R7 deadline moved", 64'(bite_req), 64'd0);
    wait_n(1);
    chk("R7 bite after new deadline", 64'(bite_req), 64'd1);
    do_reset();

    // R6: tick low freezes count
    arm(); tick = 1'b0; wait_n(30);
    chk("R6 frozen without tick", 64'(bite_req), 64'd0);
    tick = 1'b1; wait_n(P);
    chk("R6 resumed no bite yet", 64'(bite_req), 64'd0);
    wait_n(1);
    chk("R6 resumed bite", 64'(bite_req), 64'd1);
    do_reset();

    // R2: gate closed while armed
    arm(); mode_sel = 2'd1; wait_n(30); wr(BAD);
    chk("R2 gated write and tick ignored", 64'(bite_req), 64'd0);
    chk("R2 gated still live", 64'(wd_live), 64'd1);
    mode_sel = 2'd2; wait_n(P - 2);
    chk("R2 count held during gate", 64'(bite_req), 64'd0);
    do_reset();

    // R8: protocol breaks while armed
    arm(); wr(BAD);
    chk("R8 invalid key bites", 64'(bite_req), 64'd1);
    chk("R5 invalid write keeps live", 64'(wd_live), 64'd1);
    do_reset();
    arm(); wr(KB);
    chk("R8 lone second key bites", 64'(bite_req), 64'd1);
    do_reset();
    arm(); wr(KA); wr(32'h1234_4000);
    chk("R8 wrong after first key bites", 64'(bite_req), 64'd1);
    do_reset();
    arm(); wr(KA); wr(KA);
    chk("R8 repeated first key bites", 64'(bite_req), 64'd1);
    do_reset();
    arm(); wr(32'hA5C6_0000);
    chk("R8 key without enable bites", 64'(bite_req), 64'd1);
    wait_n(3);
    finish_run();
  end
endmodule